// File: doc/BRIEF.md
# Interleaved Memory Decoder Target Lookup

This block is one address decoder of the kind placed in a memory host bridge or in the upstream port of a switch. Software programs three 32-bit registers: a control word and two words that together hold a list of eight byte-wide downstream port numbers. After that, each host physical address presented on the lookup port yields a hit flag and the downstream port to which that address is interleaved. For one level of switching, two instances can be chained: the first picks the bridge's root port and the second picks the switch's downstream port.

The address is split into interleave granules of 256 << G bytes, where G is the granularity code. The ways code W picks 1, 2, 4 or 8 ways. The address bits just above the granule, taken modulo 2^W, index the target list. No lookup hits while the committed bit is clear, or while the ways code is above 3. The response is registered and held in a small state machine. RSP_IDLE means no response. RSP_HIT means a valid hit with its port number. RSP_MISS means a valid response with no target. The transitions are as follows. From any state, a cycle with no lookup goes to RSP_IDLE. A lookup that resolves goes to RSP_HIT, and a lookup that does not resolve goes to RSP_MISS. This includes HIT to MISS and MISS to HIT on back-to-back lookups.

Top module: `hdm_target_decoder`

## Requirements
- R1: After reset all three registers read as zero, and the outputs are rsp_valid=0, rsp_hit=0 and rsp_port=0.
- R2: The committed flag is bit 10 of the control word (word select 0). While it is clear, every lookup responds with rsp_hit=0 and rsp_port=0.
- R3: The granularity code G is control bits [3:0] and the ways code W is control bits [7:4]. The target index is (lk_addr >> (8+G)) mod 2^W.
- R4: Target indices 0 to 3 return bits [8i+7:8i] of the low list word (word select 1). Indices 4 to 7 return bits [8(i-4)+7:8(i-4)] of the high list word (word select 2).
- R5: A ways code above 3 makes every lookup miss, with rsp_port=0.
- R6: A lookup presented with lk_valid at a clock edge gives rsp_valid=1 exactly one cycle later. A cycle with no lookup gives rsp_valid=0, rsp_hit=0 and rsp_port=0 one cycle later. Back-to-back lookups give back-to-back responses.
- R7: A register write updates only the bytes whose wr_be bit is set. Bit b covers data bits [8b+7:8b].
- R8: A write with word select 3 changes no register.
- R9: A lookup in the same cycle as a register write uses the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Word select: 0 control, 1 list low, 2 list high, 3 unused |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables for the write |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W (48) | Host physical address to decode |
| rsp_valid | output | 1 | Response present, one cycle after lk_valid |
| rsp_hit | output | 1 | Address resolved to a target |
| rsp_port | output | 8 | Downstream port number, zero on miss |

## Verification
A stored control word that is wrong shows up at the ports on the very next lookup. A lost committed flag turns hits into misses. A wrong G or W sends addresses to the wrong list entry, and this shows only once the address bits next to the granule boundary differ across lookups. A corrupted list byte is seen only when a lookup indexes that entry, so the stimulus sweeps all eight indices. A stuck response state shows as rsp_valid or rsp_hit wrong in the cycle right after a lookup or an idle cycle.

// File: rtl/hdm_pkg.sv
package hdm_pkg;

    localparam int REG_W       = 32;
    localparam int BE_W        = REG_W / 8;
    localparam int SEL_W       = 2;
    localparam int PORT_W      = 8;
    localparam int MAX_IW      = 3;
    localparam int ENTRIES     = 1 << MAX_IW;
    localparam int IDX_W       = MAX_IW;
    localparam int GRAN_BASE   = 8;

    localparam int IG_LSB      = 0;
    localparam int IG_W        = 4;
    localparam int IW_LSB      = 4;
    localparam int IW_W        = 4;
    localparam int COMMIT_BIT  = 10;

    localparam logic [SEL_W-1:0] SEL_CTRL = 2'd0;
    localparam logic [SEL_W-1:0] SEL_TLO  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_THI  = 2'd2;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_HIT  = 2'd1,
        RSP_MISS = 2'd2
    } rsp_state_e;

    typedef struct packed {
        logic             committed;
        logic [IW_W-1:0]  ways;
        logic [IG_W-1:0]  gran;
    } ctrl_fields_t;

    function automatic ctrl_fields_t unpack_ctrl(input logic [REG_W-1:0] word);
        ctrl_fields_t f;
        f.committed = word[COMMIT_BIT];
        f.ways      = word[IW_LSB +: IW_W];
        f.gran      = word[IG_LSB +: IG_W];
        return f;
    endfunction

endpackage

// File: rtl/hdm_csr_bank.sv
module hdm_csr_bank
    import hdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [BE_W-1:0]   wr_be,
    output logic [REG_W-1:0]  ctrl_q,
    output logic [REG_W-1:0]  tlo_q,
    output logic [REG_W-1:0]  thi_q
);

    localparam int NUM_WORDS = 3;

    logic [REG_W-1:0] word_q [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic hit_w;
        assign hit_w = wr_en && (wr_sel == SEL_W'(w));
        for (genvar b = 0; b < BE_W; b++) begin : g_byte
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q[w][8*b +: 8] <= '0;
                end else if (hit_w && wr_be[b]) begin
                    word_q[w][8*b +: 8] <= wr_data[8*b +: 8];
                end
            end
        end
    end

    assign ctrl_q = word_q[SEL_CTRL];
    assign tlo_q  = word_q[SEL_TLO];
    assign thi_q  = word_q[SEL_THI];

endmodule

// File: rtl/hdm_way_index.sv
module hdm_way_index
    import hdm_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [IG_W-1:0]   gran,
    input  logic [IW_W-1:0]   ways,
    output logic [IDX_W-1:0]  idx,
    output logic              ways_ok
);

    localparam int SH_W  = $clog2(ADDR_W) + 1;
    localparam int SEL_B = $clog2(IDX_W + 1);

    logic [SH_W-1:0]   shamt;
    logic [ADDR_W-1:0] shifted;
    logic [IDX_W:0]    one_hot;
    logic [IDX_W-1:0]  mask;

    always_comb begin
        shamt   = SH_W'(GRAN_BASE) + SH_W'(gran);
        shifted = addr >> shamt;
        ways_ok = (ways <= IW_W'(MAX_IW));
        one_hot = (IDX_W+1)'(1) << ways[SEL_B-1:0];
        mask    = IDX_W'(one_hot - (IDX_W+1)'(1));
        idx     = shifted[IDX_W-1:0] & mask;
    end

endmodule

// File: rtl/hdm_port_select.sv
module hdm_port_select
    import hdm_pkg::*;
(
    input  logic [REG_W-1:0]  tlo,
    input  logic [REG_W-1:0]  thi,
    input  logic [IDX_W-1:0]  idx,
    output logic [PORT_W-1:0] port
);

    localparam int LIST_W = 2 * REG_W;

    logic [LIST_W-1:0] list_flat;
    logic [PORT_W-1:0] entry [ENTRIES];

    assign list_flat = {thi, tlo};

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        assign entry[e] = list_flat[e*PORT_W +: PORT_W];
    end

    assign port = entry[idx];

endmodule

// File: rtl/hdm_target_decoder.sv
module hdm_target_decoder
    import hdm_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [3:0]        wr_be,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [7:0]        rsp_port
);

    logic [REG_W-1:0]  ctrl_q, tlo_q, thi_q;
    ctrl_fields_t      cf;
    logic [IDX_W-1:0]  way_idx;
    logic              ways_ok;
    logic [PORT_W-1:0] sel_port;
    logic              resolves;

    rsp_state_e        state_q, state_d;
    logic [PORT_W-1:0] port_q, port_d;

    hdm_csr_bank u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .wr_be   (wr_be),
        .ctrl_q  (ctrl_q),
        .tlo_q   (tlo_q),
        .thi_q   (thi_q)
    );

    assign cf = unpack_ctrl(ctrl_q);

    hdm_way_index #(.ADDR_W(ADDR_W)) u_idx (
        .addr    (lk_addr),
        .gran    (cf.gran),
        .ways    (cf.ways),
        .idx     (way_idx),
        .ways_ok (ways_ok)
    );

    hdm_port_select u_sel (
        .tlo  (tlo_q),
        .thi  (thi_q),
        .idx  (way_idx),
        .port (sel_port)
    );

    assign resolves = cf.committed && ways_ok;

    // next-state logic
    always_comb begin
        state_d = RSP_IDLE;
        port_d  = '0;
        if (lk_valid) begin
            if (resolves) begin
                state_d = RSP_HIT;
                port_d  = sel_port;
            end else begin
                state_d = RSP_MISS;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            port_q  <= '0;
        end else begin
            state_q <= state_d;
            port_q  <= port_d;
        end
    end

    // outputs
    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_port  = '0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_port  = port_q;
            end
            RSP_MISS: rsp_valid = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/hdm_target_decoder_chk.sv
module hdm_target_decoder_chk #(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [3:0]        wr_be,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [7:0]        rsp_port,
    input logic [31:0]       ctrl_q,
    input logic [31:0]       tlo_q,
    input logic [31:0]       thi_q
);

    a_r6_lookup_answers: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit && rsp_port == 8'd0));

    a_r2_uncommitted_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !ctrl_q[10]) |=> (!rsp_hit && rsp_port == 8'd0));

    a_r5_wide_ways_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && ctrl_q[7:4] > 4'd3) |=> !rsp_hit);

    a_r4_single_way_entry0: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && ctrl_q[10] && ctrl_q[7:4] == 4'd0)
            |=> (rsp_hit && rsp_port == $past(tlo_q[7:0])));

    a_r7_masked_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && !wr_be[0]) |=> $stable(ctrl_q[7:0]));

    a_r8_unused_select: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3)
            |=> ($stable(ctrl_q) && $stable(tlo_q) && $stable(thi_q)));

    always_comb begin
        if (rst_n) begin
            a_r6_hit_implies_valid: assert (!rsp_hit || rsp_valid);
        end
    end

endmodule

bind hdm_target_decoder hdm_target_decoder_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_be     (wr_be),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_port  (rsp_port),
    .ctrl_q    (ctrl_q),
    .tlo_q     (tlo_q),
    .thi_q     (thi_q)
);

// File: tb/hdm_target_decoder_tb.sv
module hdm_target_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 48;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_sel = '0;
    logic [31:0]       wr_data = '0;
    logic [3:0]        wr_be = '0;
    logic              lk_valid = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              rsp_valid, rsp_hit;
    logic [7:0]        rsp_port;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] m_ctrl = '0, m_tlo = '0, m_thi = '0;

    bit    q_hit [$];
    byte   q_port [$];
    string q_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hdm_target_decoder #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .wr_be(wr_be), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_port(rsp_port)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic void expect_of(input logic [ADDR_W-1:0] a,
                                      output bit hit, output byte port);
        int ig, iw, idx;
        ig = int'(m_ctrl[3:0]);
        iw = int'(m_ctrl[7:4]);
        hit = 0;
        port = 0;
        if (m_ctrl[10] && iw <= 3) begin
            idx = int'((a >> (8 + ig)) % (64'd1 << iw));
            hit = 1;
            port = (idx < 4) ? m_tlo[idx*8 +: 8] : m_thi[(idx-4)*8 +: 8];
        end
    endfunction

    function automatic void model_write(input logic [1:0] s, input logic [31:0] d,
                                        input logic [3:0] be);
        for (int b = 0; b < 4; b++) begin
            if (be[b]) begin
                if (s == 2'd0) m_ctrl[b*8 +: 8] = d[b*8 +: 8];
                if (s == 2'd1) m_tlo[b*8 +: 8]  = d[b*8 +: 8];
                if (s == 2'd2) m_thi[b*8 +: 8]  = d[b*8 +: 8];
            end
        end
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 0;
            lk_valid = 0;
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        lk_valid = 0;
        wr_en = 1; wr_sel = s; wr_data = d; wr_be = be;
        model_write(s, d, be);
    endtask

    task automatic look(input logic [ADDR_W-1:0] a, input string tag);
        bit h; byte p;
        @(negedge clk);
        wr_en = 0;
        lk_valid = 1; lk_addr = a;
        expect_of(a, h, p);
        q_hit.push_back(h); q_port.push_back(p); q_tag.push_back(tag);
    endtask

    // R9: write and lookup in the same cycle; expectation uses old registers
    task automatic wr_and_look(input logic [1:0] s, input logic [31:0] d,
                               input logic [3:0] be, input logic [ADDR_W-1:0] a);
        bit h; byte p;
        @(negedge clk);
        wr_en = 1; wr_sel = s; wr_data = d; wr_be = be;
        lk_valid = 1; lk_addr = a;
        expect_of(a, h, p);
        q_hit.push_back(h); q_port.push_back(p); q_tag.push_back("R9");
        model_write(s, d, be);
    endtask

    // monitor: pops one expected item per response cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (q_hit.size() > 0) begin
                    bit h; byte p; string t;
                    h = q_hit.pop_front(); p = q_port.pop_front(); t = q_tag.pop_front();
                    check(rsp_valid == 1'b1, "R6", "rsp_valid on lookup", rsp_valid, 1);
                    check(rsp_hit == h, t, "rsp_hit", rsp_hit, h);
                    check(rsp_port == p, t, "rsp_port", rsp_port, p);
                end else begin
                    check(!rsp_valid && !rsp_hit && rsp_port == 0, "R6",
                          "idle response", {rsp_valid, rsp_hit, rsp_port}, 0);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!rsp_valid && !rsp_hit && rsp_port == 0, "R1", "reset outputs",
              {rsp_valid, rsp_hit, rsp_port}, 0);

        // R1 R2: registers zero, not committed -> miss
        look(48'h1234_5678, "R2");
        idle(2);

        // R1: commit only via byte 1; low list still zero after reset
        wr(2'd0, 32'h0000_0400, 4'b0010);
        look(48'h0, "R1");
        idle(1);

        wr(2'd1, 32'h4433_2211, 4'hF);
        wr(2'd2, 32'h8877_6655, 4'hF);
        look(48'hFFFF, "R4");

        // R4 R3: eight ways, granule 256; sweep all indices back to back (R6)
        wr(2'd0, 32'h0000_0430, 4'hF);
        for (int i = 0; i < 8; i++) look(ADDR_W'(i) << 8 | 48'h3C, "R4");
        idle(1);

        // R3: 4 ways, granule 1024, with junk in low and high bits
        wr(2'd0, 32'h0000_0422, 4'hF);
        for (int k = 0; k < 8; k++) look((ADDR_W'(k) << 10) | 48'hA000_0000_03FF & ~(48'h1C00), "R3");
        // R3: 2 ways, granule 512
        wr(2'd0, 32'h0000_0411, 4'hF);
        look(48'h200, "R3");
        look(48'h400, "R3");
        // R3: largest granule code, 4 ways
        wr(2'd0, 32'h0000_042F, 4'hF);
        look(48'h3 << 23, "R3");
        look(48'h1 << 23 | 48'h7F_FFFF, "R3");
        idle(1);

        // R5: ways codes above 3 miss
        wr(2'd0, 32'h0000_0440, 4'hF);
        look(48'h100, "R5");
        wr(2'd0, 32'h0000_0450, 4'hF);
        look(48'h0, "R5");
        idle(1);

        // R2: clear committed, keep fields
        wr(2'd0, 32'h0000_0030, 4'hF);
        look(48'h300, "R2");
        idle(1);

        // R7: byte-enable writes
        wr(2'd0, 32'h0000_0430, 4'hF);
        wr(2'd1, 32'hAAAA_AAAA, 4'b0100);
        look(48'h200, "R7");
        look(48'h100, "R7");
        look(48'h300, "R7");
        wr(2'd0, 32'hFFFF_FF00, 4'b0010);
        look(48'h500, "R7");
        idle(1);

        // R8: word select 3 leaves registers alone
        wr(2'd3, 32'h0000_0000, 4'hF);
        for (int i = 0; i < 8; i++) look(ADDR_W'(i) << 8, "R8");
        idle(1);

        // R9: same-cycle write and lookup
        wr_and_look(2'd1, 32'h0D0C_0B0A, 4'hF, 48'h000);
        look(48'h000, "R9");
        wr_and_look(2'd0, 32'h0000_0000, 4'hF, 48'h100);
        look(48'h100, "R9");
        idle(3);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule